// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block decides, once per clock, whether the processor must leave its normal instruction stream. It watches a warm-reset request, a hardware-error line, nine synchronous exception requests from the pipeline and six external interrupt lines. When any of these is present it picks a single winner. It redirects fetch in the same cycle to the vector for that class. At the next clock edge it saves the return address in an exception PC register and a reason code in a cause register, and it moves the processor into kernel mode.

The return address depends on the class of the event. Fault-type events store the PC of the instruction that failed, so that instruction can be re-run. Trap-type events and interrupts store the PC of the following instruction. A return strobe from the handler switches the processor back to user mode, arms interrupts again and sends fetch to the saved address. The cause register also mirrors the raw interrupt lines, with no masking, so the handler can see every pending source.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rstN` is low and right after it: `kernelMode`=1, `irqArmed`=0, `epc`=0, `causeCode`=0, `causePend`=0 and `redirectValid`=0.
- R2: At most one event is taken per cycle. The order, highest first, is: `resetReq`, then `hwErr`, then `excReq` (lowest set bit index wins), then an interrupt, then `rfe`.
- R3: In the same cycle as a taken event, `redirectValid`=1 and `redirectPc` is a vector chosen by class: reset 0xBFC00000, hardware error 0xBFC00100, any `excReq` bit 0x80000180, interrupt 0x80000200.
- R4: On the clock edge of a taken event, `epc` loads `curPc` for reset, hardware error and `excReq` bits 0 to 4. It loads `nextPc` for `excReq` bits 5 to 8 and for interrupts.
- R5: On a taken event, `causeCode` loads a 5-bit code. Reset gives 31, hardware error 1 and interrupt 0. The `excReq` bits 0 to 8 give 4, 2, 10, 15, 12, 13, 9, 8 and 16, in that bit order.
- R6: After every taken event, `kernelMode`=1 and `irqArmed`=0.
- R7: An interrupt is taken only when `irqGlobalEn`=1, `irqArmed`=1, `kernelMode`=0 and `irq & irqMask` is nonzero. Otherwise the interrupt lines cause no redirect.
- R8: Every cycle, `causePend` shows the `irq` value from the previous clock edge, whatever the mask and enable say.
- R9: When `rfe` is high and nothing of higher rank is taken, `redirectPc`=`epc` in that cycle. Afterwards `kernelMode`=0 and `irqArmed`=1, and `epc` and `causeCode` keep their values.
- R10: With no event and no `rfe`, `redirectValid`=0 and `epc`, `causeCode`, `kernelMode` and `irqArmed` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| curPc | input | 32 | PC of the instruction now in the exception stage |
| nextPc | input | 32 | PC of the instruction after it |
| resetReq | input | 1 | Warm-reset request |
| hwErr | input | 1 | Bus or hardware error |
| excReq | input | 9 | Synchronous exception requests, bit 0 ranks highest |
| irq | input | 6 | External interrupt lines |
| irqMask | input | 6 | Per-line interrupt mask, 1 lets the line through |
| irqGlobalEn | input | 1 | Global interrupt enable |
| rfe | input | 1 | Return-from-exception strobe |
| redirectValid | output | 1 | Fetch must go to `redirectPc` this cycle |
| redirectPc | output | 32 | Vector or return address |
| epc | output | 32 | Saved return address |
| causeCode | output | 5 | Reason code of the last taken event |
| causePend | output | 6 | Raw interrupt lines as seen at the last edge |
| kernelMode | output | 1 | 1 for kernel mode, 0 for user mode |
| irqArmed | output | 1 | Internal interrupt arm bit |

## Verification
Two pairs can land in the same cycle: a return strobe with a new event, and a synchronous exception with an enabled interrupt. The bench sets up each pair on purpose. It raises `rfe` together with `hwErr`, and it raises a trap-class `excReq` bit while an unmasked interrupt is pending in user mode. The random phase also produces many such overlaps. In each case the bench computes the winner from the rank order. It then checks the vector in the same cycle, and checks `epc`, `causeCode` and the mode bits after the edge, which shows that the losing event left no trace.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int NUM_IRQ  = 6;
  localparam int NUM_SYNC = 9;
  localparam int CODE_W   = 5;

  localparam logic [CODE_W-1:0] CODE_IRQ   = 5'd0;
  localparam logic [CODE_W-1:0] CODE_HWERR = 5'd1;
  localparam logic [CODE_W-1:0] CODE_RESET = 5'd31;

  typedef enum logic [1:0] {VEC_RST, VEC_HWE, VEC_GEN, VEC_INT} vec_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                enter;    // take an exception this cycle
    logic                leave;    // return from exception this cycle
    logic                faultPc;  // save curPc (1) or nextPc (0)
    vec_sel_e            vecSel;
    logic [CODE_W-1:0]   code;
  } exc_strobe_t;

  // reason code per synchronous request bit
  function automatic logic [CODE_W-1:0] syncCode(input int unsigned idx);
    case (idx)
      0:       syncCode = 5'd4;   // address error
      1:       syncCode = 5'd2;   // translation miss
      2:       syncCode = 5'd10;  // reserved instruction
      3:       syncCode = 5'd15;  // floating-point error
      4:       syncCode = 5'd12;  // integer overflow
      5:       syncCode = 5'd13;  // trap
      6:       syncCode = 5'd9;   // breakpoint
      7:       syncCode = 5'd8;   // system call
      default: syncCode = 5'd16;  // timer
    endcase
  endfunction
endpackage

// File: rtl/exc_ctrl.sv
`timescale 1ns/1ps
module exc_ctrl
  import exc_pkg::*;
#(
  parameter logic [NUM_SYNC-1:0] FAULT_MASK = 9'h01F
) (
  input  logic                resetReq,
  input  logic                hwErr,
  input  logic [NUM_SYNC-1:0] excReq,
  input  logic [NUM_IRQ-1:0]  irq,
  input  logic [NUM_IRQ-1:0]  irqMask,
  input  logic                irqGlobalEn,
  input  logic                kernelMode,
  input  logic                irqArmed,
  input  logic                rfe,
  output exc_strobe_t         stb
);
  localparam int IDX_W = $clog2(NUM_SYNC);

  logic [IDX_W-1:0] firstIdx;
  logic             syncHit;
  logic             irqTake;

  // lowest set request bit wins
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_SYNC - 1; i >= 0; i--) begin
      if (excReq[i]) firstIdx = IDX_W'(i);
    end
  end

  assign syncHit = |excReq;
  assign irqTake = irqGlobalEn & irqArmed & ~kernelMode & (|(irq & irqMask));

  always_comb begin
    stb        = '0;
    stb.vecSel = VEC_GEN;
    if (resetReq) begin
      stb.enter   = 1'b1;
      stb.faultPc = 1'b1;
      stb.vecSel  = VEC_RST;
      stb.code    = CODE_RESET;
    end else if (hwErr) begin
      stb.enter   = 1'b1;
      stb.faultPc = 1'b1;
      stb.vecSel  = VEC_HWE;
      stb.code    = CODE_HWERR;
    end else if (syncHit) begin
      stb.enter   = 1'b1;
      stb.faultPc = FAULT_MASK[firstIdx];
      stb.vecSel  = VEC_GEN;
      stb.code    = syncCode(int'(firstIdx));
    end else if (irqTake) begin
      stb.enter   = 1'b1;
      stb.faultPc = 1'b0;
      stb.vecSel  = VEC_INT;
      stb.code    = CODE_IRQ;
    end else if (rfe) begin
      stb.leave   = 1'b1;
    end
  end
endmodule

// File: rtl/exc_datapath.sv
`timescale 1ns/1ps
module exc_datapath
  import exc_pkg::*;
#(
  parameter int            PC_W       = 32,
  parameter logic [PC_W-1:0] VEC_RESET  = 32'hBFC0_0000,
  parameter logic [PC_W-1:0] VEC_HWERR  = 32'hBFC0_0100,
  parameter logic [PC_W-1:0] VEC_GENERAL = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_IRQ    = 32'h8000_0200
) (
  input  logic               clk,
  input  logic               rstN,
  input  exc_strobe_t        stb,
  input  logic [PC_W-1:0]    curPc,
  input  logic [PC_W-1:0]    nextPc,
  input  logic [NUM_IRQ-1:0] irq,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectPc,
  output logic [PC_W-1:0]    epc,
  output logic [CODE_W-1:0]  causeCode,
  output logic [NUM_IRQ-1:0] causePend,
  output logic               kernelMode,
  output logic               irqArmed
);
  logic [PC_W-1:0] vecPc;

  always_comb begin
    unique case (stb.vecSel)
      VEC_RST: vecPc = VEC_RESET;
      VEC_HWE: vecPc = VEC_HWERR;
      VEC_GEN: vecPc = VEC_GENERAL;
      VEC_INT: vecPc = VEC_IRQ;
    endcase
  end

  assign redirectValid = stb.enter | stb.leave;
  assign redirectPc    = stb.enter ? vecPc : (stb.leave ? epc : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epc        <= '0;
      causeCode  <= '0;
      causePend  <= '0;
      kernelMode <= 1'b1;
      irqArmed   <= 1'b0;
    end else begin
      causePend <= irq;
      if (stb.enter) begin
        epc        <= stb.faultPc ? curPc : nextPc;
        causeCode  <= stb.code;
        kernelMode <= 1'b1;
        irqArmed   <= 1'b0;
      end else if (stb.leave) begin
        kernelMode <= 1'b0;
        irqArmed   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
`timescale 1ns/1ps
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] VEC_RESET   = 32'hBFC0_0000,
  parameter logic [PC_W-1:0] VEC_HWERR   = 32'hBFC0_0100,
  parameter logic [PC_W-1:0] VEC_GENERAL = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_IRQ     = 32'h8000_0200,
  parameter logic [NUM_SYNC-1:0] FAULT_MASK = 9'h01F
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_W-1:0]     curPc,
  input  logic [PC_W-1:0]     nextPc,
  input  logic                resetReq,
  input  logic                hwErr,
  input  logic [NUM_SYNC-1:0] excReq,
  input  logic [NUM_IRQ-1:0]  irq,
  input  logic [NUM_IRQ-1:0]  irqMask,
  input  logic                irqGlobalEn,
  input  logic                rfe,
  output logic                redirectValid,
  output logic [PC_W-1:0]     redirectPc,
  output logic [PC_W-1:0]     epc,
  output logic [CODE_W-1:0]   causeCode,
  output logic [NUM_IRQ-1:0]  causePend,
  output logic                kernelMode,
  output logic                irqArmed
);
  exc_strobe_t stb;

  exc_ctrl #(.FAULT_MASK(FAULT_MASK)) u_ctrl (
    .resetReq    (resetReq),
    .hwErr       (hwErr),
    .excReq      (excReq),
    .irq         (irq),
    .irqMask     (irqMask),
    .irqGlobalEn (irqGlobalEn),
    .kernelMode  (kernelMode),
    .irqArmed    (irqArmed),
    .rfe         (rfe),
    .stb         (stb)
  );

  exc_datapath #(
    .PC_W        (PC_W),
    .VEC_RESET   (VEC_RESET),
    .VEC_HWERR   (VEC_HWERR),
    .VEC_GENERAL (VEC_GENERAL),
    .VEC_IRQ     (VEC_IRQ)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .curPc         (curPc),
    .nextPc        (nextPc),
    .irq           (irq),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .epc           (epc),
    .causeCode     (causeCode),
    .causePend     (causePend),
    .kernelMode    (kernelMode),
    .irqArmed      (irqArmed)
  );
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] VEC_RESET = 32'hBFC0_0000,
  parameter logic [PC_W-1:0] VEC_HWERR = 32'hBFC0_0100
) (
  input logic                clk,
  input logic                rstN,
  input logic [PC_W-1:0]     curPc,
  input logic [PC_W-1:0]     nextPc,
  input logic                resetReq,
  input logic                hwErr,
  input logic [NUM_SYNC-1:0] excReq,
  input logic [NUM_IRQ-1:0]  irq,
  input logic                rfe,
  input logic                redirectValid,
  input logic [PC_W-1:0]     redirectPc,
  input logic [PC_W-1:0]     epc,
  input logic [CODE_W-1:0]   causeCode,
  input logic [NUM_IRQ-1:0]  causePend,
  input logic                kernelMode,
  input logic                irqArmed
);
  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (redirectValid && redirectPc == VEC_RESET)); // R3

  AST_HWERR_RANK: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && hwErr) |-> (redirectPc == VEC_HWERR)); // R2

  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq || hwErr || excReq != '0) |=> (kernelMode && !irqArmed)); // R6

  AST_FAULT_EPC: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && !hwErr && excReq[0]) |=> (epc == $past(curPc))); // R4

  AST_TRAP_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (!resetReq && !hwErr && excReq == 9'h020) |=> (epc == $past(nextPc) && causeCode == 5'd13)); // R5

  AST_NO_IRQ_IN_KERNEL: assert property (@(posedge clk) disable iff (!rstN)
    (kernelMode && !resetReq && !hwErr && excReq == '0 && !rfe) |-> !redirectValid); // R7

  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (kernelMode && rfe && !resetReq && !hwErr && excReq == '0) |-> (redirectValid && redirectPc == epc)); // R9

  AST_RETURN_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (kernelMode && rfe && !resetReq && !hwErr && excReq == '0) |=> (!kernelMode && irqArmed && $stable(epc))); // R9

  AST_PEND_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (causePend == $past(irq))); // R8
endmodule

bind exc_entry_unit exc_entry_chk #(
  .PC_W      (PC_W),
  .VEC_RESET (VEC_RESET),
  .VEC_HWERR (VEC_HWERR)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .curPc         (curPc),
  .nextPc        (nextPc),
  .resetReq      (resetReq),
  .hwErr         (hwErr),
  .excReq        (excReq),
  .irq           (irq),
  .rfe           (rfe),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .epc           (epc),
  .causeCode     (causeCode),
  .causePend     (causePend),
  .kernelMode    (kernelMode),
  .irqArmed      (irqArmed)
);

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] curPc, nextPc;
  logic        resetReq, hwErr, irqGlobalEn, rfe;
  logic [8:0]  excReq;
  logic [5:0]  irq, irqMask;
  logic        redirectValid, kernelMode, irqArmed;
  logic [31:0] redirectPc, epc;
  logic [4:0]  causeCode;
  logic [5:0]  causePend;

  always #2.5 clk = ~clk;

  exc_entry_unit dut (
    .clk(clk), .rstN(rstN), .curPc(curPc), .nextPc(nextPc),
    .resetReq(resetReq), .hwErr(hwErr), .excReq(excReq), .irq(irq),
    .irqMask(irqMask), .irqGlobalEn(irqGlobalEn), .rfe(rfe),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .epc(epc),
    .causeCode(causeCode), .causePend(causePend), .kernelMode(kernelMode),
    .irqArmed(irqArmed)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic        mKernel, mArmed;
  logic [31:0] mEpc;
  logic [4:0]  mCode;
  logic [5:0]  mPend;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] refCode(input int i);
    logic [4:0] tbl [9] = '{5'd4, 5'd2, 5'd10, 5'd15, 5'd12, 5'd13, 5'd9, 5'd8, 5'd16};
    return tbl[i];
  endfunction

  task automatic clearIn();
    resetReq = 0; hwErr = 0; excReq = '0; irq = '0; irqMask = '0;
    irqGlobalEn = 0; rfe = 0; curPc = 32'h0; nextPc = 32'h4;
  endtask

  // one clock: comb checks before the edge, register checks after it
  task automatic cycle(input string tag);
    int kind, idx;
    bit irqOk;
    logic [31:0] vec;
    string t;
    #1;
    idx = -1;
    for (int i = 0; i < 9; i++) if (excReq[i] && idx < 0) idx = i;
    irqOk = irqGlobalEn && mArmed && !mKernel && ((irq & irqMask) != 6'd0);
    if (resetReq)       kind = 1;
    else if (hwErr)     kind = 2;
    else if (idx >= 0)  kind = 3;
    else if (irqOk)     kind = 4;
    else if (rfe)       kind = 5;
    else                kind = 0;
    case (kind)
      1: vec = 32'hBFC0_0000;
      2: vec = 32'hBFC0_0100;
      3: vec = 32'h8000_0180;
      4: vec = 32'h8000_0200;
      5: vec = mEpc;
      default: vec = 32'h0;
    endcase
    if (tag != "") t = tag;
    else if (kind == 0) t = "R10";
    else if (kind == 5) t = "R9";
    else t = "R3";
    chk(t, "redirectValid", {31'd0, redirectValid}, {31'd0, kind != 0});
    if (kind != 0) chk(t, "redirectPc", redirectPc, vec);
    @(posedge clk);
    mPend = irq;
    if (kind >= 1 && kind <= 4) begin
      mEpc    = (kind <= 2 || (kind == 3 && idx <= 4)) ? curPc : nextPc;
      mCode   = (kind == 1) ? 5'd31 : (kind == 2) ? 5'd1 : (kind == 4) ? 5'd0 : refCode(idx);
      mKernel = 1;
      mArmed  = 0;
    end else if (kind == 5) begin
      mKernel = 0;
      mArmed  = 1;
    end
    #1;
    chk("R4", "epc", epc, mEpc);
    chk("R5", "causeCode", {27'd0, causeCode}, {27'd0, mCode});
    chk("R6", "kernelMode", {31'd0, kernelMode}, {31'd0, mKernel});
    chk("R6", "irqArmed", {31'd0, irqArmed}, {31'd0, mArmed});
    chk("R8", "causePend", {26'd0, causePend}, {26'd0, mPend});
    @(negedge clk);
  endtask

  task automatic checkReset();
    chk("R1", "kernelMode", {31'd0, kernelMode}, 32'd1);
    chk("R1", "irqArmed", {31'd0, irqArmed}, 32'd0);
    chk("R1", "epc", epc, 32'd0);
    chk("R1", "causeCode", {27'd0, causeCode}, 32'd0);
    chk("R1", "causePend", {26'd0, causePend}, 32'd0);
    chk("R1", "redirectValid", {31'd0, redirectValid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7713));
    clearIn();
    rstN = 0;
    mKernel = 1; mArmed = 0; mEpc = '0; mCode = '0; mPend = '0;
    repeat (3) @(posedge clk);
    #1 checkReset();
    @(negedge clk);
    rstN = 1;
    @(posedge clk);
    #1 checkReset();
    @(negedge clk);

    // return from kernel after reset (R9)
    rfe = 1; curPc = 32'h100; nextPc = 32'h104;
    cycle("R9");
    clearIn();
    // masked interrupts ignored (R7)
    irq = 6'h3F; irqMask = 6'h00; irqGlobalEn = 1;
    cycle("R7");
    irqMask = 6'h04; irqGlobalEn = 0;
    cycle("R7");
    // enabled and unmasked: taken (R7)
    irqGlobalEn = 1; curPc = 32'h2000; nextPc = 32'h2004;
    cycle("R7");
    clearIn(); rfe = 1;
    cycle("R9");
    // trap-class request beats a live interrupt (R2)
    clearIn();
    excReq = 9'h020; irq = 6'h01; irqMask = 6'h01; irqGlobalEn = 1;
    curPc = 32'h3000; nextPc = 32'h3004;
    cycle("R2");
    // hardware error beats a return (R2)
    clearIn(); rfe = 1; hwErr = 1; curPc = 32'h4000; nextPc = 32'h4004;
    cycle("R2");
    // lowest set bit wins, fault class (R5)
    clearIn(); excReq = 9'h1F0; curPc = 32'h5000; nextPc = 32'h5008;
    cycle("R5");
    // reset beats hardware error (R3)
    clearIn(); resetReq = 1; hwErr = 1; curPc = 32'h6000;
    cycle("R3");
    clearIn();
    cycle("R10");

    for (int n = 0; n < 3000; n++) begin
      resetReq    = ($urandom_range(0, 63) == 0);
      hwErr       = ($urandom_range(0, 31) == 0);
      for (int b = 0; b < 9; b++) excReq[b] = ($urandom_range(0, 23) == 0);
      irq         = 6'($urandom);
      irqMask     = 6'($urandom);
      irqGlobalEn = ($urandom_range(0, 3) != 0);
      rfe         = ($urandom_range(0, 2) == 0);
      curPc       = {$urandom} & 32'hFFFF_FFFC;
      nextPc      = curPc + 32'd4;
      cycle("");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule